// File: doc/BRIEF.md
# Receive Interrupt Handshake Sequencer

This block follows one receive interrupt of a small multi-channel serial controller from the moment a channel asks for service until the host signals that its service routine has finished. Its state is three flags: request-enable, active and end-of-interrupt. The flags move through a fixed cycle: idle, requested, asserted, acknowledged, completed, then idle again. The block exposes these flags, together with the serviced channel and the kind of receive event, as a read-only status byte.

The controller's channels present level requests. Each request carries a bit that marks the event as an exception rather than good data. When the sequencer is idle it takes the lowest-numbered pending channel and latches that channel's index and event kind. It then waits for the fairness arbiter's grant before it raises the interrupt line. A host acknowledge drops the line and returns the two low vector bits. The sequence stays active until the host writes the receive end-of-interrupt register.

Top module: `rx_irq_seq`

## Requirements
- R1: After reset the status byte reads 0x00 and the interrupt line is low. Bit 4 of the status byte reads 0 in every state.
- R2: The flag triplet is status bits 7:5, ordered enable, active, end-of-interrupt. In idle (000), any pending channel request moves the triplet to requested (100) at the next clock.
- R3: When several channels request together, the lowest-numbered one is latched. Its index appears in status bits 1:0.
- R4: Status bits 3:2 hold the event kind: 2'b11 when the chosen channel's exception bit was 0, and 2'b00 when it was 1.
- R5: In requested (100) the triplet holds until the arbiter grant is high at a clock edge, then becomes asserted (110). An acknowledge strobe in requested has no effect.
- R6: The interrupt line is high exactly while the triplet is 110.
- R7: An acknowledge strobe in asserted moves the triplet to acknowledged (010) at the next clock. While that strobe is high in asserted, the vector output shows status bits 3:2. The vector output is 2'b00 at all other times.
- R8: An end-of-interrupt write in acknowledged moves the triplet to completed (001). Such a write in any other state is ignored.
- R9: Completed returns to 0x00 at the next clock. A request still pending then is taken one clock later.
- R10: Status bits 3:0 stay unchanged from the clock that latches them until the return to idle, whatever the request inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_req | input | NUM_CH | Level request per channel |
| rx_exc | input | NUM_CH | Per channel: 1 = exception event, 0 = good data |
| arb_grant | input | 1 | Fairness arbiter permits assertion |
| host_iack | input | 1 | Host interrupt-acknowledge strobe |
| host_eoi_wr | input | 1 | Host write to receive end-of-interrupt register |
| irq_out | output | 1 | Receive interrupt request line |
| rx_status | output | 8 | Status byte {enable, active, eoi, 0, kind[1:0], channel[1:0]} |
| vec_low | output | 2 | Low vector bits returned during acknowledge |

## Verification
The assertions assume that the exception bit of a requesting channel is steady in the cycle the request is taken. They also assume that grant, acknowledge and end-of-interrupt are plain single-cycle-sampled levels with no protocol of their own, so they may arrive in any state. The stimulus changes inputs only at the falling edge. It sweeps every request pattern against every exception mask, with grant delays of zero to two cycles. In every state that must ignore them, it deliberately sends acknowledge and end-of-interrupt strobes that are out of turn.

// File: rtl/rxi_pkg.sv
package rxi_pkg;
   // Encoding equals the {enable, active, eoi} flag triplet of the status byte.
   typedef enum logic [2:0] {
      ST_IDLE = 3'b000,
      ST_REQ  = 3'b100,
      ST_ASRT = 3'b110,
      ST_ACKD = 3'b010,
      ST_DONE = 3'b001
   } rxi_state_e;

   localparam logic [1:0] KIND_GOOD = 2'b11;
   localparam logic [1:0] KIND_EXC  = 2'b00;
   localparam int         CHAN_FIELD_W = 2;
endpackage

// File: rtl/rxi_pick.sv
module rxi_pick #(
   parameter int NUM_CH = 4,
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [NUM_CH-1:0] req,
   output logic              any,
   output logic [CH_W-1:0]   idx
);
   // Ripple from the top so the lowest set bit wins.
   logic [CH_W-1:0] stage_idx [NUM_CH+1];

   assign stage_idx[NUM_CH] = '0;
   generate
      for (genvar g = NUM_CH - 1; g >= 0; g--) begin : g_chain
         assign stage_idx[g] = req[g] ? CH_W'(g) : stage_idx[g+1];
      end
   endgenerate

   assign any = |req;
   assign idx = stage_idx[0];
endmodule

// File: rtl/rxi_seq.sv
module rxi_seq
   import rxi_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pending,
   input  logic       grant,
   input  logic       iack,
   input  logic       eoi_wr,
   output rxi_state_e state,
   output logic       take,
   output logic       finish
);
   rxi_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (pending) nxt = ST_REQ;
         ST_REQ:  if (grant)   nxt = ST_ASRT;
         ST_ASRT: if (iack)    nxt = ST_ACKD;
         ST_ACKD: if (eoi_wr)  nxt = ST_DONE;
         ST_DONE:              nxt = ST_IDLE;
         default:              nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   assign take   = (state == ST_IDLE) && pending;
   assign finish = (state == ST_DONE);
endmodule

// File: rtl/rxi_fields.sv
module rxi_fields
   import rxi_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    take,
   input  logic                    finish,
   input  logic [CH_W-1:0]         sel_idx,
   input  logic [NUM_CH-1:0]       exc,
   output logic [CHAN_FIELD_W-1:0] chan,
   output logic [1:0]              kind
);
   logic [CHAN_FIELD_W-1:0] idx_wide;

   generate
      if (CH_W < CHAN_FIELD_W) begin : g_pad
         assign idx_wide = {{(CHAN_FIELD_W - CH_W){1'b0}}, sel_idx};
      end else begin : g_same
         assign idx_wide = sel_idx;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan <= '0;
         kind <= '0;
      end else if (finish) begin
         chan <= '0;
         kind <= '0;
      end else if (take) begin
         chan <= idx_wide;
         kind <= exc[sel_idx] ? KIND_EXC : KIND_GOOD;
      end
   end
endmodule

// File: rtl/rx_irq_seq.sv
module rx_irq_seq
   import rxi_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] rx_req,
   input  logic [NUM_CH-1:0] rx_exc,
   input  logic              arb_grant,
   input  logic              host_iack,
   input  logic              host_eoi_wr,
   output logic              irq_out,
   output logic [7:0]        rx_status,
   output logic [1:0]        vec_low
);
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   generate
      if (NUM_CH < 1 || NUM_CH > (1 << CHAN_FIELD_W)) begin : g_bad_cfg
         $error("rx_irq_seq: NUM_CH must fit the channel field");
      end
   endgenerate

   logic                    any_req;
   logic [CH_W-1:0]         pick_idx;
   rxi_state_e              state;
   logic                    take;
   logic                    finish;
   logic [CHAN_FIELD_W-1:0] chan;
   logic [1:0]              kind;

   rxi_pick #(.NUM_CH(NUM_CH)) u_pick (
      .req (rx_req),
      .any (any_req),
      .idx (pick_idx)
   );

   rxi_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .pending (any_req),
      .grant   (arb_grant),
      .iack    (host_iack),
      .eoi_wr  (host_eoi_wr),
      .state   (state),
      .take    (take),
      .finish  (finish)
   );

   rxi_fields #(.NUM_CH(NUM_CH)) u_fields (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .finish  (finish),
      .sel_idx (pick_idx),
      .exc     (rx_exc),
      .chan    (chan),
      .kind    (kind)
   );

   assign irq_out   = (state == ST_ASRT);
   assign rx_status = {state, 1'b0, kind, chan};
   assign vec_low   = (irq_out && host_iack) ? kind : 2'b00;
endmodule

// File: rtl/rx_irq_seq_chk.sv
module rx_irq_seq_chk #(
   parameter int NUM_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] rx_req,
   input logic              arb_grant,
   input logic              host_iack,
   input logic              host_eoi_wr,
   input logic              irq_out,
   input logic [7:0]        rx_status,
   input logic [1:0]        vec_low
);
   logic [2:0] trip;
   assign trip = rx_status[7:5];

   // R2
   idle_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trip == 3'b000 && |rx_req) |=> trip == 3'b100);

   // R5
   grant_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trip == 3'b100 && !arb_grant) |=> trip == 3'b100);

   // R7
   ack_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trip == 3'b110 && host_iack) |=> (trip == 3'b010 && !irq_out));

   // R8
   eoi_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trip == 3'b010 && !host_eoi_wr) |=> trip == 3'b010);

   // R9
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trip == 3'b001 |=> rx_status == 8'h00);

   // R10
   field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trip != 3'b000 && trip != 3'b001) |=> $stable(rx_status[3:0]));

   // R7
   vec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_out && host_iack) |-> vec_low == 2'b00);

   // R1
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> (rx_status[4] == 1'b0 && $past(trip) == 3'b100));
endmodule

bind rx_irq_seq rx_irq_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_req      (rx_req),
   .arb_grant   (arb_grant),
   .host_iack   (host_iack),
   .host_eoi_wr (host_eoi_wr),
   .irq_out     (irq_out),
   .rx_status   (rx_status),
   .vec_low     (vec_low)
);

// File: tb/rx_irq_seq_bench.sv
module rx_irq_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] rx_req = '0;
   logic [NCH-1:0] rx_exc = '0;
   logic           arb_grant = 1'b0;
   logic           host_iack = 1'b0;
   logic           host_eoi_wr = 1'b0;
   logic           irq_out;
   logic [7:0]     rx_status;
   logic [1:0]     vec_low;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_irq_seq #(.NUM_CH(NCH)) u_rx_irq_seq (
      .clk(clk), .rst_n(rst_n), .rx_req(rx_req), .rx_exc(rx_exc),
      .arb_grant(arb_grant), .host_iack(host_iack), .host_eoi_wr(host_eoi_wr),
      .irq_out(irq_out), .rx_status(rx_status), .vec_low(vec_low)
   );

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   // Clock edge, then return at the falling edge where outputs are sampled.
   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      rx_req = '0; arb_grant = 0; host_iack = 0; host_eoi_wr = 0;
   endtask

   // Full sequence for one request pattern / exception mask / grant delay.
   task automatic run_seq(logic [3:0] pat, logic [3:0] exc, int gdly);
      int ch;
      logic [1:0] kd;
      logic [7:0] lo;
      ch = 0;
      for (int i = NCH - 1; i >= 0; i--) if (pat[i]) ch = i;
      kd = exc[ch] ? 2'b00 : 2'b11;
      lo = {3'b000, kd, 2'(ch)};

      // idle, stray eoi ignored (R8), request taken (R2, R3, R4)
      rx_req = pat; rx_exc = exc; host_eoi_wr = 1;
      cyc();
      check("R2_R3_R4 latch", rx_status, {3'b100, lo[4:0]});
      check("R6 irq low in requested", {7'd0, irq_out}, 8'd0);

      // waiting on grant: requests change, stray iack and eoi (R5, R8, R10)
      for (int d = 0; d < gdly; d++) begin
         rx_req = ~pat; rx_exc = ~exc; host_iack = 1; host_eoi_wr = 1;
         check("R7 vec quiet", {6'd0, vec_low}, 8'd0);
         cyc();
         check("R5_R10 hold requested", rx_status, {3'b100, lo[4:0]});
      end
      host_iack = 0; host_eoi_wr = 0; arb_grant = 1; rx_req = '1;
      cyc();
      check("R5 asserted", rx_status, {3'b110, lo[4:0]});
      check("R6 irq high", {7'd0, irq_out}, 8'd1);

      // stray eoi in asserted (R8)
      arb_grant = 0; host_eoi_wr = 1;
      cyc();
      check("R8 eoi ignored asserted", rx_status, {3'b110, lo[4:0]});

      // acknowledge (R7)
      host_eoi_wr = 0; host_iack = 1;
      #1;
      check("R7 vector during ack", {6'd0, vec_low}, {6'd0, kd});
      cyc();
      check("R7 acknowledged", rx_status, {3'b010, lo[4:0]});
      check("R6 irq low after ack", {7'd0, irq_out}, 8'd0);
      check("R7 vec quiet after ack", {6'd0, vec_low}, 8'd0);

      // no eoi yet: stays (R8), then eoi
      host_iack = 0; rx_req = '0;
      cyc();
      check("R8 waits for eoi", rx_status, {3'b010, lo[4:0]});
      host_eoi_wr = 1;
      cyc();
      check("R8 completed", rx_status, {3'b001, lo[4:0]});
      host_eoi_wr = 0;
      cyc();
      check("R9 back to idle", rx_status, 8'h00);
      check("R1 reserved bit", {7'd0, rx_status[4]}, 8'd0);
   endtask

   initial begin
      idle_inputs();
      repeat (2) @(negedge clk);
      check("R1 reset status", rx_status, 8'h00);
      check("R1 reset irq", {7'd0, irq_out}, 8'd0);
      rst_n = 1;
      @(negedge clk);
      cyc();
      check("R2 no request stays idle", rx_status, 8'h00);

      for (int p = 1; p < 16; p++)
         for (int e = 0; e < 16; e++)
            run_seq(4'(p), 4'(e), (p + e) % 3);

      // back-to-back: request held through completion (R9)
      rx_req = 4'b1000; rx_exc = 4'b0000;
      cyc();
      check("R3 single high channel", rx_status, 8'b1000_1111);
      arb_grant = 1; cyc(); arb_grant = 0;
      host_iack = 1; cyc(); host_iack = 0;
      host_eoi_wr = 1; cyc(); host_eoi_wr = 0;
      check("R8 completed b2b", rx_status, 8'b0010_1111);
      cyc();
      check("R9 idle between", rx_status, 8'h00);
      cyc();
      check("R9 next request taken", rx_status, 8'b1000_1111);
      idle_inputs();

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule